// File: doc/BRIEF.md
# Multi-Format Serial Audio Framer

This block is the framing core of a serial audio port that always runs as a clock and frame slave. An external master supplies the bit clock and the frame sync. The block counts bit and slot positions inside a time-division frame. It shifts parallel sample words out on a serial data line and collects the received serial bits back into words. One datapath handles four frame-sync conventions. In two of them the sync arrives one bit before the data (a level that lasts half a frame, or a single-bit pulse). In the other two the sync is aligned with the first data bit (again as a half-frame level or as a single-bit pulse). Each direction has its own slot mask.

The serial pins are sampled into the system clock domain through two flops, and edges of the bit clock are found there. The port therefore needs a system clock several times faster than the bit clock; with the default depth, more than four system cycles per bit. Words cross the parallel side through a valid/ready pair in each direction, and each direction holds one word. Settings are written through a small write-only port. While either direction is enabled the settings are locked, and a write that is refused raises a one-cycle error flag.

Top module: `sap_framer`

## Requirements
- R1: With format code 0 (register 0 bits [1:0]), the sync is active low. The first bit of slot 0 is the bit that follows the bit in which the sync is first seen active.
- R2: With format code 1, the sync is active high, and the bit in which it is first seen active is the first bit of slot 0.
- R3: With format code 2, a one-bit-wide high sync pulse marks the bit just before the first bit of slot 0.
- R4: With format code 3, a one-bit-wide high sync pulse is coincident with the first bit of slot 0.
- R5: With register 0 bit 2 clear, sdi and fsync are sampled on the rising bit-clock edge and sdo changes after the falling edge; setting bit 2 swaps the two edges. Register 0 bit 3 inverts the sync level for every format.
- R6: Register 0 bits [5:4] choose the word length: 0 for 16 bits, 1 for 20 bits, 2 for 24 bits. Words go out and come in MSB first, starting at the first bit of the slot. On transmit, the bits of a slot past the word length are zero, and so are the data bits above the word length. On receive, those extra bits are ignored and the word is returned right-aligned.
- R7: Register 1 holds the number of slots minus one, and each slot is SLOT_BITS bit clocks long. The slot counter wraps at the end of the frame, and each new sync pulls it back to slot 0.
- R8: Register 2 is the transmit slot mask (bit n stands for slot n). In a masked slot, sdo_oe and sdo stay low and no word is taken from tx_data.
- R9: Register 3 is the receive slot mask. A masked slot produces no word on rx_data.
- R10: A write to register 0 that asks for master mode (bit 6) or for word-length code 3 is refused: cfg_err pulses and the old settings stay.
- R11: While port_en is high, writes to registers 0 to 3 are refused with a cfg_err pulse and have no effect. Register 4 ([0] transmit enable, [1] receive enable) can always be written.
- R12: port_en is the OR of the two enables. The transmitter starts at the first frame start it can predict, which is the first frame for formats 0 and 2 and the second frame for formats 1 and 3. When the port is disabled, sdo_oe and tx_ready stay low.
- R13: rx_valid stays high until rx_ready is seen. A newer word replaces one that has not been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 3 | Settings register select (0 to 4) |
| cfg_wdata | input | CFG_W | Settings write data |
| cfg_err | output | 1 | One-cycle pulse after a refused write |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | DATA_W | Transmit word, right-aligned |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_valid | output | 1 | Received word available |
| rx_data | output | DATA_W | Received word, right-aligned |
| rx_ready | input | 1 | Received word accepted |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | External frame sync |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| port_en | output | 1 | Either direction enabled |

## Verification
The bench goes after the sync alignment of each of the four formats. A design that treats an early sync as an aligned one would shift every word by one bit, so both the received and the transmitted words come out wrong. Runs with the edges and the sync level inverted expose a design that samples on the wrong edge, which produces words shifted by half a bit or garbled. Pad bits past the word length are driven as ones on sdi, which catches a receiver that keeps shifting past the word length. Locked and refused writes are followed by traffic under the old settings, and the hold test stalls rx_ready across two frames: a design that let a bad write through, or that dropped or kept the wrong pending word, would show wrong words.

// File: rtl/sap_framer.sv
module sap_framer #(
  parameter int MAX_SLOTS = 8,
  parameter int SLOT_BITS = 32,
  parameter int DATA_W    = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_addr,
  input  logic [((MAX_SLOTS > 8) ? MAX_SLOTS : 8)-1:0] cfg_wdata,
  output logic                 cfg_err,
  input  logic                 tx_valid,
  input  logic [DATA_W-1:0]    tx_data,
  output logic                 tx_ready,
  output logic                 rx_valid,
  output logic [DATA_W-1:0]    rx_data,
  input  logic                 rx_ready,
  input  logic                 bclk,
  input  logic                 fsync,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic                 port_en
);
  localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;
  localparam int BW = $clog2(SLOT_BITS);

  logic [1:0]           fmt, wlc;
  logic                 binv, finv, tx_en, rx_en;
  logic [SW-1:0]        nsm1;
  logic [MAX_SLOTS-1:0] txm, rxm;
  logic [BW:0]          wl;

  always_comb
    case (wlc)
      2'd0:    wl = (BW+1)'(16);
      2'd1:    wl = (BW+1)'(20);
      default: wl = (BW+1)'(24);
    endcase

  assign port_en = tx_en | rx_en;

  logic bad;
  assign bad = cfg_we && ((cfg_addr <= 3'd3 && port_en) || cfg_addr > 3'd4 ||
               (cfg_addr == 3'd0 && (cfg_wdata[6] || cfg_wdata[5:4] == 2'b11)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_err <= 1'b0;
      {fmt, binv, finv, wlc} <= '0;
      nsm1 <= '0; txm <= '0; rxm <= '0;
      tx_en <= 1'b0; rx_en <= 1'b0;
    end else begin
      cfg_err <= bad;
      if (cfg_we && !bad)
        case (cfg_addr)
          3'd0: {wlc, finv, binv, fmt} <= cfg_wdata[5:0];
          3'd1: nsm1 <= cfg_wdata[SW-1:0];
          3'd2: txm  <= cfg_wdata[MAX_SLOTS-1:0];
          3'd3: rxm  <= cfg_wdata[MAX_SLOTS-1:0];
          default: {rx_en, tx_en} <= cfg_wdata[1:0];
        endcase
    end

  logic b_s1, b_s2, b_s3, f_s1, f_s2, d_s1, d_s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {b_s1, b_s2, b_s3, f_s1, f_s2, d_s1, d_s2} <= '0;
    else begin
      b_s1 <= bclk;  b_s2 <= b_s1; b_s3 <= b_s2;
      f_s1 <= fsync; f_s2 <= f_s1;
      d_s1 <= sdi;   d_s2 <= d_s1;
    end

  logic smp, lch;
  assign smp = (b_s2 ^ binv) & ~(b_s3 ^ binv);
  assign lch = ~(b_s2 ^ binv) & (b_s3 ^ binv);

  logic early, fs_act, fs_prev, fs_rise;
  assign early   = (fmt == 2'd0) || (fmt == 2'd2);
  assign fs_act  = f_s2 ^ finv ^ (fmt == 2'd0);
  assign fs_rise = fs_act & ~fs_prev;

  logic          run, pend;
  logic [BW-1:0] bpos, ab, nb, tb;
  logic [SW-1:0] spos, as_, ns, ts;
  logic          start, tknown;

  assign ab     = (bpos == BW'(SLOT_BITS-1)) ? '0 : bpos + 1'b1;
  assign as_    = (bpos != BW'(SLOT_BITS-1)) ? spos : (spos == nsm1) ? '0 : spos + 1'b1;
  assign start  = early ? pend : fs_rise;
  assign nb     = start ? '0 : ab;
  assign ns     = start ? '0 : as_;
  assign tb     = pend ? '0 : ab;
  assign ts     = pend ? '0 : as_;
  assign tknown = run | pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {run, pend, fs_prev} <= '0; bpos <= '0; spos <= '0;
    end else if (!port_en) begin
      {run, pend, fs_prev} <= '0; bpos <= '0; spos <= '0;
    end else if (smp) begin
      fs_prev <= fs_act;
      pend    <= early & fs_rise;
      run     <= start | run;
      bpos    <= nb;
      spos    <= ns;
    end

  logic [DATA_W-2:0] rx_sh;
  logic [DATA_W-1:0] word_in;
  assign word_in = (nb == '0) ? DATA_W'(d_s2) : {rx_sh, d_s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh <= '0; rx_data <= '0; rx_valid <= 1'b0;
    end else begin
      if (rx_ready) rx_valid <= 1'b0;
      if (smp && port_en && rx_en && (start | run) && {1'b0, nb} < wl) begin
        rx_sh <= word_in[DATA_W-2:0];
        if ({1'b0, nb} == wl - 1'b1 && rxm[ns]) begin
          rx_data  <= word_in;
          rx_valid <= 1'b1;
        end
      end
    end

  logic              tx_sync, slot_on, sync_eff, on, bitv;
  logic [DATA_W-1:0] tx_word, src, shv;
  logic [BW:0]       idx;

  assign sync_eff = tx_sync | (tb == '0 && ts == '0);
  assign tx_ready = lch && port_en && tx_en && tknown && sync_eff && tb == '0 && txm[ts];
  assign src      = (tb == '0) ? (tx_valid ? tx_data : '0) : tx_word;
  assign idx      = wl - 1'b1 - {1'b0, tb};
  assign shv      = src >> idx;
  assign bitv     = shv[0];
  assign on       = (tb == '0) ? txm[ts] : slot_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {tx_sync, slot_on, sdo, sdo_oe} <= '0; tx_word <= '0;
    end else if (!port_en || !tx_en) begin
      {tx_sync, slot_on, sdo, sdo_oe} <= '0;
    end else if (lch) begin
      if (!tknown) begin
        sdo <= 1'b0; sdo_oe <= 1'b0;
      end else begin
        tx_sync <= sync_eff;
        if (tb == '0) begin
          slot_on <= txm[ts];
          tx_word <= src;
        end
        sdo_oe <= sync_eff && on;
        sdo    <= sync_eff && on && ({1'b0, tb} < wl) && bitv;
      end
    end
endmodule

// File: rtl/sap_framer_chk.sv
module sap_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic       mreq,
  input logic       cfg_err,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       sdo,
  input logic       sdo_oe,
  input logic       port_en
);
  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr <= 3'd3 && port_en |=> cfg_err);
  // R10
  master_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 3'd0 && mreq |=> cfg_err);
  // R13
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);
  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  // R12
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !sdo_oe && !tx_ready);
  // R12
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);
endmodule

bind sap_framer sap_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .mreq(cfg_wdata[6]), .cfg_err(cfg_err), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .sdo(sdo), .sdo_oe(sdo_oe),
  .port_en(port_en)
);

// File: tb/sap_framer_bench.sv
module sap_framer_bench;
  localparam int MS = 8, SB = 32, DW = 24, HALF = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cfg_we = 1'b0, tx_valid = 1'b1, rx_ready = 1'b1;
  logic bclk = 1'b0, fsync = 1'b0, sdi = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [DW-1:0] tx_data = 24'h5A1234;
  logic cfg_err, tx_ready, rx_valid, sdo, sdo_oe, port_en;
  logic [DW-1:0] rx_data;

  sap_framer #(.MAX_SLOTS(MS), .SLOT_BITS(SB), .DATA_W(DW)) u_sap_framer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .bclk(bclk), .fsync(fsync),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .port_en(port_en));

  int checks = 0, fails = 0;
  string tag = "R0";
  logic [DW-1:0] txq[$];
  logic [DW-1:0] rxq[$];
  logic hold_mode = 1'b0;
  logic [DW-1:0] last_rx;
  int m_fmt, m_wl, m_slots;
  logic m_binv, m_finv, m_txen, m_rxen;
  logic [MS-1:0] m_txm, m_rxm;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [DW-1:0] wmask(int wl);
    return DW'((32'h1 << wl) - 1);
  endfunction

  function automatic logic [DW-1:0] rxw(int f, int s);
    return DW'(32'hC35A96 ^ (f * 32'h01F3B1) ^ (s * 32'h2D0749));
  endfunction

  // transmit driver: push each accepted word, then present a new one
  initial forever begin
    @(negedge clk);
    if (tx_ready && tx_valid) begin
      txq.push_back(tx_data & wmask(m_wl));
      @(posedge clk); #1;
      tx_data = tx_data + 24'h3B5D7 ^ 24'hF00F00;
    end
  end

  // receive monitor
  initial forever begin
    @(negedge clk);
    if (!hold_mode && rx_valid && rx_ready) begin
      if (rxq.size() == 0) begin
        checks++; fails++;
        $display("FAIL %s R9 unexpected rx word actual=%h expected=none", tag, rx_data);
      end else chk({tag, " R6 rx word"}, 32'(rx_data), 32'(rxq.pop_front()));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d, output logic err);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    err = cfg_err;
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic configure(int fmt, logic bi, logic fi, int wlc, int slots,
                           logic [MS-1:0] tm, logic [MS-1:0] rm);
    logic e;
    wr(3'd0, 8'(fmt | (bi << 2) | (fi << 3) | (wlc << 4)), e);
    wr(3'd1, 8'(slots - 1), e);
    wr(3'd2, tm, e);
    wr(3'd3, rm, e);
    m_fmt = fmt; m_binv = bi; m_finv = fi; m_slots = slots;
    m_wl = (wlc == 0) ? 16 : (wlc == 1) ? 20 : 24;
    m_txm = tm; m_rxm = rm;
  endtask

  task automatic enable(logic t, logic r);
    logic e;
    bclk = m_binv;
    fsync = (m_fmt == 0) ^ m_finv;
    repeat (4) @(negedge clk);
    m_txen = t; m_rxen = r;
    wr(3'd4, {6'd0, r, t}, e);
    chk("R12 port_en", 32'(port_en), 32'(t | r));
    repeat (4) @(negedge clk);
  endtask

  task automatic disable_port();
    logic e;
    wr(3'd4, 8'd0, e);
    chk("R12 port_en off", 32'(port_en), 32'd0);
    repeat (4) @(negedge clk);
  endtask

  task automatic frames(int nf);
    int F = m_slots * SB;
    int seen = 0, want = 0;
    logic [SB-1:0] cap = '0;
    logic oe0 = 1'b0, oeany = 1'b0, oeall = 1'b1;
    for (int s = 0; s < m_slots; s++) if (m_txm[s]) want++;
    want = m_txen ? want * ((m_fmt == 0 || m_fmt == 2) ? nf : nf - 1) : 0;
    for (int k = 0; k < 1 + nf * F; k++) begin
      int g = (k + F - 1) % F;
      int fr = (k == 0) ? -1 : (k - 1) / F;
      int s = g / SB;
      int b = g % SB;
      logic act;
      logic [DW-1:0] w;
      case (m_fmt)
        0: act = ((g + 1) % F) < F / 2;
        1: act = g < F / 2;
        2: act = (g == F - 1);
        default: act = (g == 0);
      endcase
      w = rxw(fr, s);
      bclk = m_binv;
      fsync = act ^ (m_fmt == 0) ^ m_finv;
      sdi = (fr >= 0 && b < m_wl) ? w[m_wl - 1 - b] : 1'b1;
      if (fr >= 0 && b == 0 && m_rxen && m_rxm[s]) begin
        if (hold_mode) last_rx = w & wmask(m_wl);
        else rxq.push_back(w & wmask(m_wl));
      end
      repeat (HALF) @(negedge clk);
      if (fr >= 0) begin
        if (b == 0) begin cap = '0; oe0 = sdo_oe; oeany = 1'b0; oeall = 1'b1; end
        cap = {cap[SB-2:0], sdo};
        oeany |= sdo_oe; oeall &= sdo_oe;
        if (b == SB - 1) begin
          if (!m_txen || !m_txm[s])
            chk({tag, " R8 masked slot quiet"}, 32'(oeany | (cap != 0)), 32'd0);
          else if (oe0) begin
            seen++;
            chk({tag, " R8 oe held for slot"}, 32'(oeall), 32'd1);
            if (txq.size() == 0) begin
              checks++; fails++;
              $display("FAIL %s R6 tx slot without word actual=%h expected=none", tag, cap);
            end else chk({tag, " R6 tx slot"}, 32'(cap), 32'(txq.pop_front()) << (SB - m_wl));
          end
        end
      end
      bclk = ~m_binv;
      repeat (HALF) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chk({tag, " R12 tx slot count"}, 32'(seen), 32'(want));
    chk({tag, " R9 rx words drained"}, 32'(rxq.size()), 32'd0);
    chk({tag, " R8 tx words drained"}, 32'(txq.size()), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    logic e;
    m_fmt = 0; m_wl = 16; m_slots = 1; m_binv = 0; m_finv = 0;
    m_txen = 0; m_rxen = 0; m_txm = '0; m_rxm = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset port_en", 32'(port_en), 32'd0);
    chk("R12 reset tx_ready", 32'(tx_ready), 32'd0);
    chk("R13 reset rx_valid", 32'(rx_valid), 32'd0);
    chk("R8 reset sdo_oe", 32'(sdo_oe), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 reset cfg_err", 32'(cfg_err), 32'd0);

    tag = "R1"; configure(0, 0, 0, 0, 2, 8'h03, 8'h03);
    enable(1, 1); frames(3); disable_port();
    tag = "R2"; configure(1, 0, 0, 2, 2, 8'h03, 8'h03);
    enable(1, 1); frames(3); disable_port();
    tag = "R3"; configure(2, 0, 0, 1, 4, 8'h05, 8'h0A);
    enable(1, 1); frames(3); disable_port();
    tag = "R4 R7"; configure(3, 0, 0, 0, 8, 8'h81, 8'h3C);
    enable(1, 1); frames(2); disable_port();
    tag = "R5 inv"; configure(0, 1, 1, 2, 2, 8'h02, 8'h03);
    enable(1, 1); frames(3); disable_port();
    tag = "R5 bclk"; configure(3, 1, 0, 1, 3, 8'h07, 8'h05);
    enable(1, 1); frames(3); disable_port();

    tag = "R11"; configure(1, 0, 0, 0, 2, 8'h03, 8'h01);
    enable(1, 1);
    wr(3'd0, 8'h02, e); chk("R11 locked format write", 32'(e), 32'd1);
    wr(3'd2, 8'h00, e); chk("R11 locked mask write", 32'(e), 32'd1);
    frames(2); disable_port();

    tag = "R10"; configure(0, 0, 0, 1, 2, 8'h01, 8'h03);
    wr(3'd0, 8'h41, e); chk("R10 master request refused", 32'(e), 32'd1);
    wr(3'd0, 8'h31, e); chk("R10 word code 3 refused", 32'(e), 32'd1);
    wr(3'd5, 8'h00, e); chk("R10 bad address refused", 32'(e), 32'd1);
    enable(1, 1); frames(2); disable_port();

    tag = "R12 tx only"; configure(2, 0, 0, 0, 2, 8'h03, 8'h03);
    enable(1, 0); frames(2); disable_port();
    tag = "R12 rx only";
    enable(0, 1); frames(2); disable_port();

    tag = "R13"; configure(3, 0, 0, 0, 1, 8'h00, 8'h01);
    rx_ready = 1'b0; hold_mode = 1'b1;
    enable(0, 1); frames(2);
    chk("R13 valid held", 32'(rx_valid), 32'd1);
    chk("R13 newest word kept", 32'(rx_data), 32'(last_rx));
    rx_ready = 1'b1;
    @(negedge clk);
    chk("R13 valid cleared on ready", 32'(rx_valid), 32'd0);
    hold_mode = 1'b0;
    disable_port();

    report();
  end
endmodule